// File: doc/BRIEF.md
# Coprocessor In-Flight Instruction Tracker

This block follows instructions that a processor has handed to a coprocessor but not yet resolved. Each accepted instruction occupies one slot. A slot holds the instruction's identifier, a live flag and a committed flag. Identifiers are arbitrary values with no ordering between them. Every lookup is therefore a plain equality compare against all slots in parallel. Two slots may even hold the same identifier.

Three message streams arrive, each carrying at most one item per cycle:
- An issue port fills a free slot.
- A resolution port either commits or kills every slot holding the named identifier.
- A retire port releases committed slots as their results complete. Retirement may come in any order, as it does when an iterative divider or a separate conversion path finishes behind or ahead of the main pipeline.

A combinational query port tells the surrounding pipeline whether a given identifier is still live and whether it has been committed. A sticky error flag records any resolution that named an identifier with no live slot.

Top module: `cpt_inflight_tracker`

## Requirements
- R1: After reset no slot is live. `occupancy` is 0, `full` and `err_sticky` are 0, and `qry_live` and `qry_committed` are 0 for every identifier.
- R2: When `iss_valid` is 1 and `full` is 0, one slot is filled with `iss_id` on that clock edge. From the next cycle the identifier reads live and uncommitted (unless R7 applies), and `occupancy` rises by one. At most one instruction is accepted per cycle.
- R3: `full` is 1 exactly when all ENTRIES slots are live, and `iss_ready` is its inverse. An issue presented while `full` is 1 is dropped: the identifier does not become live and `occupancy` does not rise.
- R4: A resolution with `res_kill`=1 clears, at the next edge, every live slot whose identifier equals `res_id`. Slots holding other identifiers keep their state.
- R5: A resolution with `res_kill`=0 sets the committed flag, at the next edge, in every live slot whose identifier equals `res_id`. Matching is by equality only, with no assumption on issue order.
- R6: `ret_valid` with `ret_id` frees, at the next edge, every slot that was live and already committed with that identifier. A retire that names an uncommitted or absent identifier has no effect. Retirement order is free.
- R7: If an issue is accepted in the same cycle as a resolution naming the same identifier, that resolution applies to the new slot:
  - a kill leaves it not live, with no occupancy rise;
  - a commit makes it live and committed at once.
- R8: A resolution whose identifier matches no live slot, and no issue accepted in the same cycle, changes no slot. It sets `err_sticky` at the next edge, and the flag then holds until reset.
- R9: `qry_live` is 1 in the same cycle when some live slot holds `qry_id`. `qry_committed` is 1 when some such slot is also committed.
- R10: `occupancy` always equals the number of live slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Issue request this cycle |
| iss_id | input | ID_W | Identifier of the issued instruction |
| iss_ready | output | 1 | A free slot exists; issue will be accepted |
| res_valid | input | 1 | Resolution message present |
| res_kill | input | 1 | 1 = kill, 0 = commit |
| res_id | input | ID_W | Identifier being resolved |
| ret_valid | input | 1 | Retire request present |
| ret_id | input | ID_W | Identifier of a completed, committed instruction |
| qry_id | input | ID_W | Identifier to look up |
| qry_live | output | 1 | Some live slot holds qry_id |
| qry_committed | output | 1 | Some live, committed slot holds qry_id |
| full | output | 1 | All slots live |
| occupancy | output | $clog2(ENTRIES+1) | Number of live slots |
| err_sticky | output | 1 | A resolution missed every slot since reset |

## Verification
The directed patterns each separate one pair of behaviours:
- Issuing three distinct identifiers and then committing, retiring and killing them out of issue order shows that matching is by equality and not by position.
- Filling every slot with a repeated identifier, then pushing one more issue, separates a dropped issue from an overwritten slot. Killing the repeated value then shows that every copy clears while its neighbours survive.
- Same-cycle issue-plus-kill and issue-plus-commit pairs tell the bypass path apart from the error path.
- A kill of an absent identifier, and a retire of an uncommitted one, show that a miss is flagged without touching any slot.

A long random stretch over a narrow identifier range then forces frequent duplicates, collisions and full stalls. Each cycle is checked against a queue-based model.

// File: rtl/cpt_pkg.sv
package cpt_pkg;

  typedef enum logic {
    RES_COMMIT = 1'b0,
    RES_KILL   = 1'b1
  } res_kind_e;

  typedef struct packed {
    logic live;
    logic committed;
  } slot_state_t;

endpackage

// File: rtl/cpt_slot.sv
module cpt_slot
  import cpt_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc,
  input  logic [ID_W-1:0] alloc_id,
  input  logic            res_valid,
  input  res_kind_e       res_kind,
  input  logic [ID_W-1:0] res_id,
  input  logic            ret_valid,
  input  logic [ID_W-1:0] ret_id,
  output slot_state_t     state,
  output logic [ID_W-1:0] id,
  output logic            res_match
);

  logic ret_match;
  logic bypass_hit;

  assign res_match  = res_valid && state.live && (id == res_id);
  assign ret_match  = ret_valid && state.live && state.committed && (id == ret_id);
  assign bypass_hit = res_valid && (alloc_id == res_id);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= '0;
      id    <= '0;
    end else if (alloc) begin
      id              <= alloc_id;
      state.live      <= !(bypass_hit && res_kind == RES_KILL);
      state.committed <= bypass_hit && res_kind == RES_COMMIT;
    end else if ((res_match && res_kind == RES_KILL) || ret_match) begin
      state <= '0;
    end else if (res_match && res_kind == RES_COMMIT) begin
      state.committed <= 1'b1;
    end
  end

endmodule

// File: rtl/cpt_alloc.sv
module cpt_alloc #(
  parameter int N = 8
) (
  input  logic [N-1:0] free_vec,
  output logic [N-1:0] grant,
  output logic         any_free
);

  function automatic logic [N-1:0] lowest_set(input logic [N-1:0] v);
    return v & (~v + N'(1));
  endfunction

  assign grant    = lowest_set(free_vec);
  assign any_free = |free_vec;

endmodule

// File: rtl/cpt_lookup.sv
module cpt_lookup
  import cpt_pkg::*;
#(
  parameter int N    = 8,
  parameter int ID_W = 4
) (
  input  slot_state_t     states [N],
  input  logic [ID_W-1:0] ids    [N],
  input  logic [ID_W-1:0] key,
  output logic            hit_live,
  output logic            hit_committed
);

  logic [N-1:0] eq_live;
  logic [N-1:0] eq_comm;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq_live[g] = states[g].live && (ids[g] == key);
    assign eq_comm[g] = eq_live[g] && states[g].committed;
  end

  assign hit_live      = |eq_live;
  assign hit_committed = |eq_comm;

endmodule

// File: rtl/cpt_inflight_tracker.sv
module cpt_inflight_tracker
  import cpt_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ID_W    = 4,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [ID_W-1:0]  iss_id,
  output logic             iss_ready,
  input  logic             res_valid,
  input  logic             res_kill,
  input  logic [ID_W-1:0]  res_id,
  input  logic             ret_valid,
  input  logic [ID_W-1:0]  ret_id,
  input  logic [ID_W-1:0]  qry_id,
  output logic             qry_live,
  output logic             qry_committed,
  output logic             full,
  output logic [CNT_W-1:0] occupancy,
  output logic             err_sticky
);

  function automatic logic [CNT_W-1:0] popcount(input logic [ENTRIES-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < ENTRIES; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  res_kind_e        res_kind;
  slot_state_t      slot_st  [ENTRIES];
  logic [ID_W-1:0]  slot_id  [ENTRIES];
  logic [ENTRIES-1:0] live_vec;
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] grant;
  logic               any_free;

  // named events for the checker
  logic iss_accept;
  logic res_hit_any;
  logic res_bypass;
  logic res_miss;

  assign res_kind = res_kill ? RES_KILL : RES_COMMIT;

  cpt_alloc #(.N(ENTRIES)) u_alloc (
    .free_vec (~live_vec),
    .grant    (grant),
    .any_free (any_free)
  );

  assign iss_accept = iss_valid && any_free;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    cpt_slot #(.ID_W(ID_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc     (iss_accept && grant[g]),
      .alloc_id  (iss_id),
      .res_valid (res_valid),
      .res_kind  (res_kind),
      .res_id    (res_id),
      .ret_valid (ret_valid),
      .ret_id    (ret_id),
      .state     (slot_st[g]),
      .id        (slot_id[g]),
      .res_match (match_vec[g])
    );
    assign live_vec[g] = slot_st[g].live;
  end

  cpt_lookup #(.N(ENTRIES), .ID_W(ID_W)) u_lookup (
    .states        (slot_st),
    .ids           (slot_id),
    .key           (qry_id),
    .hit_live      (qry_live),
    .hit_committed (qry_committed)
  );

  assign res_hit_any = |match_vec;
  assign res_bypass  = res_valid && iss_accept && (iss_id == res_id);
  assign res_miss    = res_valid && !res_hit_any && !res_bypass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_sticky <= 1'b0;
    else if (res_miss) err_sticky <= 1'b1;
  end

  assign full      = &live_vec;
  assign iss_ready = !full;
  assign occupancy = popcount(live_vec);

endmodule

// File: rtl/cpt_tracker_chk.sv
module cpt_tracker_chk #(
  parameter int ENTRIES = 8,
  parameter int ID_W    = 4,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic             res_valid,
  input logic             res_kill,
  input logic [ID_W-1:0]  res_id,
  input logic             ret_valid,
  input logic [ID_W-1:0]  qry_id,
  input logic             qry_live,
  input logic             qry_committed,
  input logic             full,
  input logic [CNT_W-1:0] occupancy,
  input logic             err_sticky,
  input logic             res_miss
);

  assert_full_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> occupancy == CNT_W'(ENTRIES));

  assert_no_issue_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !res_valid && !ret_valid) |=> occupancy == $past(occupancy));

  assert_one_issue_per_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> {1'b0, occupancy} <= {1'b0, $past(occupancy)} + 1'b1);

  assert_kill_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kill && qry_id == res_id) |=> (!$stable(qry_id) || !qry_live));

  assert_commit_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_kill && qry_id == res_id && !res_miss)
      |=> (!$stable(qry_id) || !qry_live || qry_committed));

  assert_miss_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_miss |=> err_sticky);

  assert_err_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!iss_valid && !res_valid && !ret_valid) |=> $stable(occupancy));

endmodule

bind cpt_inflight_tracker cpt_tracker_chk #(.ENTRIES(ENTRIES), .ID_W(ID_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .iss_valid     (iss_valid),
  .res_valid     (res_valid),
  .res_kill      (res_kill),
  .res_id        (res_id),
  .ret_valid     (ret_valid),
  .qry_id        (qry_id),
  .qry_live      (qry_live),
  .qry_committed (qry_committed),
  .full          (full),
  .occupancy     (occupancy),
  .err_sticky    (err_sticky),
  .res_miss      (res_miss)
);

// File: tb/cpt_inflight_tracker_tb.sv
module cpt_inflight_tracker_tb;

  localparam int N     = 8;
  localparam int IW    = 4;
  localparam int CW    = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iss_valid = 1'b0, res_valid = 1'b0, res_kill = 1'b0, ret_valid = 1'b0;
  logic [IW-1:0] iss_id = '0, res_id = '0, ret_id = '0, qry_id = '0;
  logic          iss_ready, qry_live, qry_committed, full, err_sticky;
  logic [CW-1:0] occupancy;

  int checks = 0;
  int errors = 0;

  // behavioural reference
  int mid[$];
  bit mcm[$];
  bit merr = 1'b0;

  always #5 clk = ~clk;

  cpt_inflight_tracker #(.ENTRIES(N), .ID_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_id(iss_id), .iss_ready(iss_ready),
    .res_valid(res_valid), .res_kill(res_kill), .res_id(res_id),
    .ret_valid(ret_valid), .ret_id(ret_id),
    .qry_id(qry_id), .qry_live(qry_live), .qry_committed(qry_committed),
    .full(full), .occupancy(occupancy), .err_sticky(err_sticky)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit m_live(input int k);
    foreach (mid[i]) if (mid[i] == k) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit m_comm(input int k);
    foreach (mid[i]) if (mid[i] == k && mcm[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_update();
    bit acc;
    bit hit;
    int rid;
    int tid;
    int nid[$];
    bit ncm[$];
    acc = iss_valid && (mid.size() < N);
    rid = int'(res_id);
    tid = int'(ret_id);
    hit = m_live(rid) || (acc && iss_id == res_id);
    foreach (mid[i]) begin
      bit keep;
      bit c;
      keep = 1'b1;
      c = mcm[i];
      if (ret_valid && mid[i] == tid && mcm[i]) keep = 1'b0;
      if (res_valid && mid[i] == rid) begin
        if (res_kill) keep = 1'b0;
        else c = 1'b1;
      end
      if (keep) begin
        nid.push_back(mid[i]);
        ncm.push_back(c);
      end
    end
    if (acc && !(res_valid && res_kill && iss_id == res_id)) begin
      nid.push_back(int'(iss_id));
      ncm.push_back(res_valid && !res_kill && iss_id == res_id);
    end
    if (res_valid && !hit) merr = 1'b1;
    mid = nid;
    mcm = ncm;
  endtask

  task automatic compare_state(input string tag);
    check("R10", int'(occupancy), mid.size(), "occupancy");
    check("R3", int'(full), int'(mid.size() == N), "full");
    check("R3", int'(iss_ready), int'(mid.size() != N), "iss_ready");
    check("R8", int'(err_sticky), int'(merr), {tag, " err_sticky"});
  endtask

  // one cycle: drive after negedge, check query, clock, check registered state
  task automatic step(input bit iv, input int iid, input bit rv, input bit rk, input int rid,
                      input bit tv, input int tid, input int qid, input string tag);
    iss_valid = iv; iss_id = IW'(iid);
    res_valid = rv; res_kill = rk; res_id = IW'(rid);
    ret_valid = tv; ret_id = IW'(tid);
    qry_id = IW'(qid);
    #1;
    check(tag, int'(qry_live), int'(m_live(qid)), "qry_live");
    check(tag, int'(qry_committed), int'(m_comm(qid)), "qry_committed");
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_state(tag);
  endtask

  task automatic idle_q(input int qid, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, qid, tag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(occupancy), 0, "occupancy");
    check("R1", int'(full), 0, "full");
    check("R1", int'(err_sticky), 0, "err_sticky");
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 16; k++) idle_q(k, "R1");

    // R2: three distinct issues
    step(1, 3, 0, 0, 0, 0, 0, 3, "R2");
    step(1, 7, 0, 0, 0, 0, 0, 3, "R2");
    step(1, 11, 0, 0, 0, 0, 0, 7, "R2");
    idle_q(11, "R2");
    // R5: commit the middle one, out of order
    step(0, 0, 1, 0, 7, 0, 0, 7, "R5");
    idle_q(7, "R5");
    idle_q(3, "R5");
    // R6: retire uncommitted id 3 ignored, then retire committed id 7
    step(0, 0, 0, 0, 0, 1, 3, 3, "R6");
    idle_q(3, "R6");
    step(0, 0, 0, 0, 0, 1, 7, 7, "R6");
    idle_q(7, "R6");
    // R4: kill id 3, id 11 untouched
    step(0, 0, 1, 1, 3, 0, 0, 3, "R4");
    idle_q(3, "R4");
    idle_q(11, "R4");

    // R3: fill with duplicate id 5, then overflow attempt with id 9
    for (int i = 0; i < N - 1; i++) step(1, (i % 2) ? 5 : 12 + (i % 4) / 2, 0, 0, 0, 0, 0, 5, "R3");
    step(1, 9, 0, 0, 0, 0, 0, 9, "R3");
    idle_q(9, "R3");
    // R4: kill every copy of 5, others stay
    step(0, 0, 1, 1, 5, 0, 0, 5, "R4");
    idle_q(5, "R4");
    idle_q(12, "R4");

    // R7: issue+kill same id, issue+commit same id
    step(1, 2, 1, 1, 2, 0, 0, 2, "R7");
    idle_q(2, "R7");
    step(1, 4, 1, 0, 4, 0, 0, 4, "R7");
    idle_q(4, "R7");
    check("R7", int'(err_sticky), 0, "no error on bypass");

    // R8: kill of absent id
    step(0, 0, 1, 1, 15, 0, 0, 11, "R8");
    idle_q(11, "R8");
    check("R8", int'(err_sticky), 1, "sticky set");

    // drain then random mix over a narrow id range
    for (int k = 0; k < 16; k++) step(0, 0, 1, 1, k, 0, 0, k, "R4");
    for (int c = 0; c < 600; c++) begin
      int r;
      r = $urandom;
      step(r[0] | r[1], r[5:3], r[6] & r[7], r[8], r[11:9],
           r[12], r[15:13], r[18:16], "R9");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule